// File: doc/BRIEF.md
# Four-channel simultaneous-sampling converter host bus interface

This block is the digital host-facing side of a converter that samples up to four inputs on the same conversion clock edge. On each rising edge of the conversion clock it captures one 12-bit word per channel from a result source, holds the whole set for a fixed five-edge latency, and then lets a host fetch the channel words one per read strobe in the order A, B, C, D. The number of channels in the scan (2, 3 or 4) and the strobe style are set by a control register that the host writes over the same 12-bit bus. The two top bus lines carry the register address during a write.

The host selects the block with a pair of chip selects, one active low and one active high. One strobe pin can act as a combined read/not-write line, or as a write-only strobe beside a separate active-low read strobe. A sync output marks the moments when the next word to be read belongs to channel A, so the host can align to the scan. The bidirectional bus is brought out as an input, an output and an output enable. The pad-level tri-state buffer sits outside this block. All logic runs on one system clock, and both edges of the conversion clock are detected synchronously.

Top module: `mcadc_bus_if`

## Requirements
- R1: The output enable `bus_oe` is 1 only while `cs_n` is 0 and `cs` is 1 and a read is in progress. Under any other chip select combination the bus is released.
- R2: The block captures a write on the first system clock cycle in which it is selected with `wr_rw` low. Bits [11:10] give the address: 0 selects control register 0, 1 selects control register 1, and 2 or 3 discard the write. Bits [9:0] give the stored value.
- R3: Control register 0 bits [1:0] hold the scan length minus one. A value of 0 is treated as 1, so the scan covers two channels. Bit 2 set selects the write-only strobe style.
- R4: In combined style (bit 2 clear), a read runs while the block is selected with `wr_rw` high. `rd_n` has no effect, and one continuous select is one read however often `rd_n` toggles.
- R5: In write-only style (bit 2 set), a read runs while the block is selected with `rd_n` low. Selecting with `wr_rw` high and `rd_n` high does not drive the bus and does not advance the channel order.
- R6: Until the first write to control register 0 after reset, reads leave `bus_oe` at 0. A write to any other address does not end this state.
- R7: The sample set captured at conversion clock rising edge n is the one read out after edge n+5. Reads made before the first such set is available return 0.
- R8: Each completed read moves to the next channel in the order A, B, C, D. After the last channel of the configured scan length, the order returns to A.
- R9: Every rising edge of the conversion clock that brings a new sample set restarts the order at channel A, however many reads were made.
- R10: `sync` changes only on falling edges of the conversion clock. At each falling edge it becomes 1 exactly when a valid sample set is held and the next read will return channel A.
- R11: All words of one set come from the same sampling edge. Channel c is taken from `smp_words` bits [12c+11:12c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_clk | input | 1 | Conversion clock, synchronous to `clk`; samples are taken on its rising edge |
| cs_n | input | 1 | Chip select, active low |
| cs | input | 1 | Chip select, active high |
| wr_rw | input | 1 | Combined read/not-write line, or active-low write strobe in write-only style |
| rd_n | input | 1 | Active-low read strobe, used only in write-only style |
| bus_in | input | 12 | Bus value as seen at the pins (write data and address) |
| bus_out | output | 12 | Registered read data |
| bus_oe | output | 1 | Registered enable for the pad tri-state driver |
| smp_words | input | 48 | One 12-bit result per channel from the result source, channel A in the low bits |
| sync | output | 1 | Marks that channel A is next on the bus |

## Verification
The result source stub gives each word a channel tag in bits [10:8] and the sampling edge count in its low byte, so a mismatch shows whether the channel or the latency is wrong. Directed periods cover the edges right around the five-edge latency, full four-word scans, one-word partial scans, the clamp of a zero scan length, writes to the ignored addresses, and both strobe styles, including `rd_n` toggling inside a combined-style read. A seeded random phase then changes the scan length, strobe style and register address at random, and issues 0 to 4 reads per period. This separates wrap-around from restart-on-new-set, and shows whether `sync` follows the pointer at the falling edge.

// File: rtl/mcadc_pkg.sv
package mcadc_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL0 = 2'd0,
    REG_CTRL1 = 2'd1
  } reg_addr_e;

  typedef struct packed {
    logic       wonly;
    logic [1:0] cnt_m1;
  } strobe_cfg_t;
endpackage

// File: rtl/mcadc_cfg_regs.sv
module mcadc_cfg_regs #(
  parameter int unsigned DW = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_act_i,
  input  logic [DW-1:0]         bus_i,
  output logic                  cfg_valid_o,
  output mcadc_pkg::strobe_cfg_t cfg_o
);
  import mcadc_pkg::*;
  localparam int unsigned REG_W = DW - ADDR_W;

  logic             wr_prev;
  logic             wr_fire;
  logic [ADDR_W-1:0] addr;
  logic [REG_W-1:0] payload;
  logic [REG_W-1:0] reg0_q;
  logic [REG_W-1:0] reg1_q;

  assign wr_fire = wr_act_i & ~wr_prev;
  assign addr    = bus_i[DW-1 -: ADDR_W];
  assign payload = bus_i[REG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev     <= 1'b0;
      cfg_valid_o <= 1'b0;
      reg0_q      <= '0;
      reg1_q      <= '0;
    end else begin
      wr_prev <= wr_act_i;
      if (wr_fire) begin
        if (addr == REG_CTRL0) begin
          reg0_q      <= payload;
          cfg_valid_o <= 1'b1;
        end else if (addr == REG_CTRL1) begin
          reg1_q <= payload;
        end
      end
    end
  end

  assign cfg_o.cnt_m1 = reg0_q[1:0];
  assign cfg_o.wonly  = reg0_q[2];

  // R2: registers change only through a write to their own address
  assert_reg0_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_fire && addr == REG_CTRL0) |=> $stable(reg0_q));
  assert_reg1_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_fire && addr == REG_CTRL1) |=> $stable(reg1_q));
  // R6: configuration becomes valid only through a control register 0 write
  assert_first_write_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_valid_o) |-> $past(wr_fire && addr == REG_CTRL0));
endmodule

// File: rtl/mcadc_sample_pipe.sv
module mcadc_sample_pipe #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 12,
  parameter int unsigned LAT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic [NCH*DW-1:0] smp_i,
  output logic [NCH*DW-1:0] set_o,
  output logic              set_vld_o
);
  localparam int unsigned SW = NCH * DW;
  localparam int unsigned CW = $clog2(LAT + 2);
  localparam logic [CW-1:0] FILL_MAX = CW'(LAT + 1);

  logic [SW-1:0]  stage [LAT];
  logic [LAT-1:0] svld;
  logic [CW-1:0]  fill_cnt;

  // data stages carry no reset so they can map to plain registers or RAM
  always_ff @(posedge clk) begin
    if (rise_i) begin
      stage[0] <= smp_i;
      for (int i = 1; i < LAT; i++) stage[i] <= stage[i-1];
      set_o <= stage[LAT-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svld      <= '0;
      set_vld_o <= 1'b0;
      fill_cnt  <= '0;
    end else if (rise_i) begin
      svld      <= {svld[LAT-2:0], 1'b1};
      set_vld_o <= svld[LAT-1];
      if (fill_cnt != FILL_MAX) fill_cnt <= fill_cnt + CW'(1);
    end
  end

  // R7: a set is presented only after LAT+1 sampling edges since reset
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    set_vld_o |-> fill_cnt == FILL_MAX);
  // R11: whole set moves together, only on sampling edges
  assert_set_stable_R11: assert property (@(posedge clk) disable iff (rst)
    !rise_i |=> $stable(set_vld_o));
endmodule

// File: rtl/mcadc_readout.sv
module mcadc_readout #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              rd_act_i,
  input  logic [1:0]        cnt_m1_i,
  input  logic [NCH*DW-1:0] set_i,
  input  logic              set_vld_i,
  output logic [DW-1:0]     dout_o,
  output logic              sync_o
);
  localparam int unsigned PW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [PW-1:0] MAXP = PW'(NCH - 1);

  logic [DW-1:0] words [NCH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] last;
  logic [1:0]    req;
  logic          rd_prev;
  logic          rd_done;

  for (genvar g = 0; g < NCH; g++) begin : g_word
    assign words[g] = set_i[g*DW +: DW];
  end

  always_comb begin
    req = (cnt_m1_i == 2'd0) ? 2'd1 : cnt_m1_i;
    if (int'(req) > NCH - 1) last = MAXP;
    else                     last = PW'(req);
  end

  assign rd_done = rd_prev & ~rd_act_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      rd_prev <= 1'b0;
      dout_o  <= '0;
      sync_o  <= 1'b0;
    end else begin
      rd_prev <= rd_act_i;
      if (rise_i)       ptr <= '0;
      else if (rd_done) ptr <= (ptr >= last) ? '0 : ptr + PW'(1);
      dout_o <= set_vld_i ? words[ptr] : '0;
      if (fall_i) sync_o <= set_vld_i && (ptr == '0);
    end
  end

  // R8: a read finished on the last channel returns to channel A
  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !rise_i && ptr >= last) |=> ptr == '0);
  // R9: a new set always restarts at channel A
  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    rise_i |=> ptr == '0);
  // R10: sync moves only after a conversion clock falling edge
  assert_sync_edge_R10: assert property (@(posedge clk) disable iff (rst)
    !fall_i |=> $stable(sync_o));
endmodule

// File: rtl/mcadc_bus_if.sv
module mcadc_bus_if #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 12,
  parameter int unsigned LAT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_clk,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              wr_rw,
  input  logic              rd_n,
  input  logic [DW-1:0]     bus_in,
  output logic [DW-1:0]     bus_out,
  output logic              bus_oe,
  input  logic [NCH*DW-1:0] smp_words,
  output logic              sync
);
  import mcadc_pkg::*;

  logic        conv_q;
  logic        rise;
  logic        fall;
  logic        sel;
  logic        wr_act;
  logic        rd_act;
  logic        cfg_valid;
  strobe_cfg_t cfg;
  logic [NCH*DW-1:0] set_w;
  logic        set_vld;

  always_ff @(posedge clk) begin
    if (rst) conv_q <= 1'b0;
    else     conv_q <= conv_clk;
  end

  assign rise   = conv_clk & ~conv_q;
  assign fall   = ~conv_clk & conv_q;
  assign sel    = ~cs_n & cs;
  assign wr_act = sel & ~wr_rw;
  assign rd_act = sel & cfg_valid & ~wr_act & (cfg.wonly ? ~rd_n : wr_rw);

  mcadc_cfg_regs #(.DW(DW)) cfg_i (
    .clk         (clk),
    .rst         (rst),
    .wr_act_i    (wr_act),
    .bus_i       (bus_in),
    .cfg_valid_o (cfg_valid),
    .cfg_o       (cfg)
  );

  mcadc_sample_pipe #(.NCH(NCH), .DW(DW), .LAT(LAT)) pipe_i (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise),
    .smp_i     (smp_words),
    .set_o     (set_w),
    .set_vld_o (set_vld)
  );

  mcadc_readout #(.NCH(NCH), .DW(DW)) rdo_i (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise),
    .fall_i    (fall),
    .rd_act_i  (rd_act),
    .cnt_m1_i  (cfg.cnt_m1),
    .set_i     (set_w),
    .set_vld_i (set_vld),
    .dout_o    (bus_out),
    .sync_o    (sync)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_oe <= 1'b0;
    else     bus_oe <= rd_act;
  end

  // R1: a deselected block never drives in the following cycle
  assert_hiz_unsel_R1: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !bus_oe);
  // R6: no drive before the strobe style is known
  assert_no_drive_unconf_R6: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> cfg_valid);
  // R4: in combined style a low read/not-write line never drives
  assert_comb_write_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg.wonly && !wr_rw) |=> !bus_oe);
endmodule

// File: tb/mcadc_bus_if_tb_top.sv
module mcadc_bus_if_tb_top;
  localparam int NCH = 4, DW = 12, LAT = 5, HALF = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic conv_clk = 1'b0, cs_n = 1'b1, cs = 1'b0, wr_rw = 1'b1, rd_n = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out;
  logic bus_oe, sync;
  logic [NCH*DW-1:0] smp;

  int n_r = 0, cdiv = 0, checks = 0, fails = 0;
  bit gen_en = 0, done = 0;
  int m_cnt = 3, m_ptr = 0;
  bit m_wonly = 0;

  always #5 clk = ~clk;

  mcadc_bus_if #(.NCH(NCH), .DW(DW), .LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .conv_clk(conv_clk), .cs_n(cs_n), .cs(cs),
    .wr_rw(wr_rw), .rd_n(rd_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .smp_words(smp), .sync(sync));

  function automatic logic [DW-1:0] fw(int m, int c);
    return DW'(((c + 1) << 8) | (m & 255));
  endfunction

  function automatic logic [NCH*DW-1:0] pack(int m);
    logic [NCH*DW-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*DW +: DW] = fw(m, c);
    return v;
  endfunction

  function automatic int m_last();
    return (m_cnt == 0) ? 1 : m_cnt;
  endfunction

  function automatic logic [DW-1:0] exp_word(int c);
    return (n_r >= LAT + 1) ? fw(n_r - LAT - 1, c) : '0;
  endfunction

  initial smp = pack(0);

  // conversion clock and result source stub
  always @(negedge clk) if (gen_en) begin
    if (cdiv == 0) begin conv_clk <= 1'b1; n_r <= n_r + 1; end
    else if (cdiv == HALF) begin conv_clk <= 1'b0; smp <= pack(n_r); end
    cdiv <= (cdiv == 2*HALF - 1) ? 0 : cdiv + 1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(int addr, int val);
    @(negedge clk);
    bus_in = {2'(addr), 10'(val)};
    wr_rw = 1'b0; cs_n = 1'b0; cs = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; cs = 1'b0; wr_rw = 1'b1;
    @(negedge clk);
    if (addr == 0) begin m_cnt = val & 3; m_wonly = val[2]; end
  endtask

  task automatic do_read(output logic [DW-1:0] v, output logic oe);
    @(negedge clk);
    wr_rw = 1'b1; cs_n = 1'b0; cs = 1'b1;
    if (m_wonly) rd_n = 1'b0;
    repeat (2) @(negedge clk);
    v = bus_out; oe = bus_oe;
    cs_n = 1'b1; cs = 1'b0; rd_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_chk(string req);
    logic [DW-1:0] v, e;
    logic oe;
    e = exp_word(m_ptr);
    do_read(v, oe);
    chk(oe == 1'b1, {req, " oe"}, int'(oe), 1);
    chk(v == e, {req, " word"}, int'(v), int'(e));
    m_ptr = (m_ptr >= m_last()) ? 0 : m_ptr + 1;
  endtask

  task automatic wait_rise();
    @(posedge conv_clk);
    repeat (2) @(negedge clk);
    m_ptr = 0;
  endtask

  task automatic wait_fall_chk(string req);
    bit es;
    @(negedge conv_clk);
    repeat (2) @(negedge clk);
    es = (n_r >= LAT + 1) && (m_ptr == 0);
    chk(sync == es, req, int'(sync), int'(es));
  endtask

  task automatic sel_try(logic n, logic p, string req);
    @(negedge clk);
    wr_rw = 1'b1; cs_n = n; cs = p;
    repeat (3) @(negedge clk);
    chk(bus_oe == 1'b0, req, int'(bus_oe), 0);
    cs_n = 1'b1; cs = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] v;
    logic oe;
    void'($urandom(32'h5eed_1207));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_oe == 1'b0, "R1 reset oe", int'(bus_oe), 0);
    chk(sync == 1'b0, "R10 reset sync", int'(sync), 0);

    // R6: reads before configuration, both strobe styles, and after a reg1 write
    do_read(v, oe);
    chk(oe == 1'b0, "R6 combined read unconfigured", int'(oe), 0);
    m_wonly = 1; do_read(v, oe); m_wonly = 0;
    chk(oe == 1'b0, "R6 write-only read unconfigured", int'(oe), 0);
    do_write(1, 10'h3FF);
    do_read(v, oe);
    chk(oe == 1'b0, "R6 reg1 write does not configure", int'(oe), 0);

    do_write(0, 3);
    // R1: partial chip select combinations
    sel_try(1'b0, 1'b0, "R1 cs low");
    sel_try(1'b1, 1'b1, "R1 cs_n high");
    sel_try(1'b1, 1'b0, "R1 both inactive");

    gen_en = 1;
    for (int i = 0; i < 5; i++) wait_rise();
    read_chk("R7 before latency");            // rise 5: no set yet, expect 0
    wait_fall_chk("R10 no valid set");

    wait_rise();                               // rise 6: first set
    for (int i = 0; i < 4; i++) read_chk("R7 R8 R11 full scan");
    wait_fall_chk("R10 sync after wrap");

    wait_rise();
    read_chk("R8 partial");
    wait_fall_chk("R10 sync off channel A");
    do_write(0, 1);

    wait_rise();
    for (int i = 0; i < 3; i++) read_chk("R3 R8 two-channel wrap");
    wait_fall_chk("R10 two-channel");
    do_write(0, 0);

    wait_rise();
    for (int i = 0; i < 3; i++) read_chk("R3 zero count clamp");
    wait_fall_chk("R10 clamp");

    wait_rise();
    read_chk("R9 restart first");
    wait_fall_chk("R10 restart");
    do_write(2, 3);
    wait_rise();
    read_chk("R9 restart at A");
    wait_fall_chk("R10 after ignored write");
    do_write(1, 4);

    wait_rise();
    for (int i = 0; i < 3; i++) read_chk("R2 ignored address writes");
    wait_fall_chk("R10 after reg1 write");
    do_write(0, 4 | 3);

    // R5: write-only style
    wait_rise();
    @(negedge clk);
    wr_rw = 1'b1; rd_n = 1'b1; cs_n = 1'b0; cs = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_oe == 1'b0, "R5 wr_rw high alone", int'(bus_oe), 0);
    cs_n = 1'b1; cs = 1'b0;
    @(negedge clk);
    read_chk("R5 rd_n read A");
    read_chk("R5 rd_n read B");
    wait_fall_chk("R10 write-only");
    do_write(0, 3);

    // R4: rd_n toggles inside one combined-style read
    wait_rise();
    @(negedge clk);
    wr_rw = 1'b1; cs_n = 1'b0; cs = 1'b1;
    for (int i = 0; i < 3; i++) begin
      rd_n = 1'b0; @(negedge clk); rd_n = 1'b1; @(negedge clk);
    end
    chk(bus_out == exp_word(0), "R4 word during toggles", int'(bus_out), int'(exp_word(0)));
    cs_n = 1'b1; cs = 1'b0;
    repeat (2) @(negedge clk);
    m_ptr = 1;
    read_chk("R4 next is channel B");
    wait_fall_chk("R10 combined");

    // random phase
    for (int it = 0; it < 40; it++) begin
      int nrd;
      wait_rise();
      nrd = int'($urandom % 5);
      for (int k = 0; k < nrd; k++) read_chk("R8 R9 random");
      wait_fall_chk("R10 random");
      if ($urandom % 2 == 0) do_write(int'($urandom % 4), int'($urandom % 1024));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule